// File: doc/BRIEF.md
# I2C SCL Clock Pacer with Launch and Sample Strobes

This block paces the serial clock of an I2C master from the core clock. A programmable divider sets the SCL period in core clocks. Each period has a driven-low half followed by a released half. Two programmable delays place a pair of one-cycle strobes. The launch strobe tells the bit engine when to change SDA after SCL has gone low. The sample strobe tells it when to capture SDA after SCL has been seen high.

The block watches the real SCL line. When a target holds the line low after the block has released it, the released half waits until the line is seen high, so targets can stretch the clock. Start and stop conditions and byte framing belong to the bit engine that uses these strobes. While `en` is low the block idles with SCL released and both strobes quiet. Raising `en` starts a new period with a low half.

Top module: `scl_pacer`

## Requirements
- R1: While `rst` is high, and on the cycle after any clock edge where `en` is low, `scl_o` is 1 and both strobes are 0.
- R2: The half period H equals `div_cfg[15:1]`, so bit 0 of the divider has no effect. With the line free, `scl_o` stays low for exactly H cycles and then high for exactly H cycles, which gives a period of 2·H core clocks.
- R3: A divider whose bits 15:1 are all zero (the values 0 and 1) gives H = 32767, the longest even period.
- R4: `launch_stb` is a single-cycle pulse once per period, exactly Dl cycles after the first cycle in which `scl_o` is low. Dl comes from `edge_dly[31:16]`.
- R5: `sample_stb` is a single-cycle pulse once per period, exactly Ds cycles after the first cycle in which `scl_o` is high and `scl_in` is seen high. Ds comes from `edge_dly[15:0]`.
- R6: A delay field equal to 0 acts as 1.
- R7: A delay field larger than H acts as H.
- R8: In the released half, each clock edge at which `scl_in` is low leaves `scl_o` high and adds one cycle to that half. The sample strobe is measured from the cycle in which the line is first seen high.
- R9: The first clock edge with `en` high after idle drives `scl_o` low, whatever the level of `scl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces idle |
| div_cfg | input | 16 | Period divider; bit 0 is ignored |
| edge_dly | input | 32 | Launch delay in bits 31:16, sample delay in bits 15:0 |
| scl_in | input | 1 | Observed SCL line level, already synchronous to clk |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| launch_stb | output | 1 | One-cycle pulse: drive the next SDA bit now |
| sample_stb | output | 1 | One-cycle pulse: sample SDA now |

## Verification
The assertions assume that `div_cfg` and `edge_dly` stay stable while `en` is high. They also assume that `scl_in` is already synchronous and can only be low while `scl_o` is released if some target holds it. The bench makes `scl_in` the wired-AND of `scl_o` and a stretch hold. It changes the configuration only on cycles where `en` is low, and it keeps `en` low throughout reset. Random cases pick the divider, both delays (including values above H) and the stretch length. Directed cases cover the smallest divider, an odd divider, delays equal to H, and the maximum-period divider values.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam int NUM_STB = 2;
  localparam int STB_LAUNCH = 0;
  localparam int STB_SAMPLE = 1;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode #(
  parameter int DIVW = 16,
  parameter int DW   = 16,
  localparam int HW  = DIVW - 1
) (
  input  logic [DIVW-1:0] div_cfg,
  input  logic [2*DW-1:0] edge_dly,
  output logic [HW-1:0]   half,
  output logic [DW-1:0]   dly_eff [scl_pacer_pkg::NUM_STB]
);
  import scl_pacer_pkg::*;

  logic [HW-1:0] half_raw;
  logic [DW-1:0] dly_raw [NUM_STB];
  logic [DW-1:0] half_ext;

  // Bit 0 dropped: period always even; zero maps to the longest period.
  assign half_raw = div_cfg[DIVW-1:1];
  assign half     = (half_raw == '0) ? '1 : half_raw;
  assign half_ext = DW'(half);

  assign dly_raw[STB_LAUNCH] = edge_dly[2*DW-1:DW];
  assign dly_raw[STB_SAMPLE] = edge_dly[DW-1:0];

  for (genvar g = 0; g < NUM_STB; g++) begin : g_clamp
    always_comb begin
      if (dly_raw[g] == '0)
        dly_eff[g] = DW'(1);
      else if (dly_raw[g] > half_ext)
        dly_eff[g] = half_ext;
      else
        dly_eff[g] = dly_raw[g];
    end
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          scl_in,
  input  logic [HW-1:0] half,
  output logic          scl_o,
  output logic          launch_load,
  output logic          sample_load
);
  import scl_pacer_pkg::*;

  logic          active;
  scl_phase_e    phase;
  logic [HW-1:0] cnt;
  logic          scl_q;
  logic          last;

  assign last = (cnt == half - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0;
      phase  <= PH_LOW;
      cnt    <= '0;
      scl_q  <= 1'b1;
    end else if (!active) begin
      active <= 1'b1;
      phase  <= PH_LOW;
      cnt    <= '0;
      scl_q  <= 1'b0;
    end else begin
      case (phase)
        PH_LOW: begin
          if (last) begin
            phase <= PH_HIGH;
            cnt   <= '0;
            scl_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (scl_in) begin
            if (last) begin
              phase <= PH_LOW;
              cnt   <= '0;
              scl_q <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign scl_o       = scl_q;
  // Each delay starts counting at the edge that ends the first cycle of its level.
  assign launch_load = active && (phase == PH_LOW)  && (cnt == '0);
  assign sample_load = active && (phase == PH_HIGH) && (cnt == '0) && scl_in;
endmodule

// File: rtl/scl_edge_delay.sv
module scl_edge_delay #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] dly,
  output logic          stb
);
  logic          armed;
  logic [DW-1:0] rem;
  logic          stb_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      armed <= 1'b0;
      rem   <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (load) begin
        if (dly == DW'(1)) begin
          stb_q <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed <= 1'b1;
          rem   <= dly - 1'b1;
        end
      end else if (armed) begin
        if (rem == DW'(1)) begin
          stb_q <= 1'b1;
          armed <= 1'b0;
        end else begin
          rem <= rem - 1'b1;
        end
      end
    end
  end

  assign stb = stb_q;
endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
  parameter int DIVW = 16,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DIVW-1:0] div_cfg,
  input  logic [2*DW-1:0] edge_dly,
  input  logic            scl_in,
  output logic            scl_o,
  output logic            launch_stb,
  output logic            sample_stb
);
  import scl_pacer_pkg::*;

  localparam int HW = DIVW - 1;

  logic [HW-1:0] half;
  logic [DW-1:0] dly_eff [NUM_STB];
  logic          load    [NUM_STB];
  logic          stb     [NUM_STB];

  scl_cfg_decode #(.DIVW(DIVW), .DW(DW)) u_cfg (
    .div_cfg  (div_cfg),
    .edge_dly (edge_dly),
    .half     (half),
    .dly_eff  (dly_eff)
  );

  scl_phase_ctrl #(.HW(HW)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .scl_in      (scl_in),
    .half        (half),
    .scl_o       (scl_o),
    .launch_load (load[STB_LAUNCH]),
    .sample_load (load[STB_SAMPLE])
  );

  for (genvar g = 0; g < NUM_STB; g++) begin : g_dly
    scl_edge_delay #(.DW(DW)) u_dly (
      .clk  (clk),
      .rst  (rst),
      .clr  (!en),
      .load (load[g]),
      .dly  (dly_eff[g]),
      .stb  (stb[g])
    );
  end

  assign launch_stb = stb[STB_LAUNCH];
  assign sample_stb = stb[STB_SAMPLE];
endmodule

// File: rtl/scl_pacer_chk.sv
module scl_pacer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic scl_in,
  input logic scl_o,
  input logic launch_stb,
  input logic sample_stb
);
  // R1: disabled means idle on the next cycle
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !launch_stb && !sample_stb));

  // R4: launch strobe follows a low cycle
  a_r4_after_fall: assert property (@(posedge clk) disable iff (rst)
    launch_stb |-> !$past(scl_o));

  // R5: sample strobe follows a released cycle
  a_r5_after_rise: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> $past(scl_o));

  // R4, R5: the two strobes never coincide
  a_r4_r5_apart: assert property (@(posedge clk) disable iff (rst)
    !(launch_stb && sample_stb));

  // R8: a held-low line keeps the released half going
  a_r8_stretch_hold: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && !$past(rst) && scl_o && !scl_in) |=> scl_o);
endmodule

bind scl_pacer scl_pacer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .scl_in     (scl_in),
  .scl_o      (scl_o),
  .launch_stb (launch_stb),
  .sample_stb (sample_stb)
);

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] div_cfg = 16'd4;
  logic [31:0] edge_dly = 32'd0;
  logic        hold = 1'b0;
  logic        scl_in;
  logic        scl_o, launch_stb, sample_stb;
  int          checks = 0;
  int          errors = 0;

  assign scl_in = scl_o & ~hold;

  always #5 clk = ~clk;

  scl_pacer u0 (
    .clk(clk), .rst(rst), .en(en), .div_cfg(div_cfg), .edge_dly(edge_dly),
    .scl_in(scl_in), .scl_o(scl_o), .launch_stb(launch_stb), .sample_stb(sample_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_half(input int d);
    int h;
    h = (d >> 1) & 32'h7fff;
    return (h == 0) ? 32767 : h;
  endfunction

  function automatic int eff_dly(input int d, input int h);
    if (d == 0) return 1;
    if (d > h) return h;
    return d;
  endfunction

  function automatic string dtag(input int d, input int h, input string base);
    if (d == 0) return "R6";
    if (d > h) return "R7";
    return base;
  endfunction

  task automatic run_case(input int dv, input int ld, input int sd, input int st);
    int h, le, se, r_exp, fall2_exp, t, scnt;
    int rise_t, fall2_t, l1, s1, l2, nl, ns;
    bit prev;
    string ptag;
    h = eff_half(dv);
    le = eff_dly(ld, h);
    se = eff_dly(sd, h);
    r_exp = 1 + h + st;
    fall2_exp = r_exp + h;
    ptag = (dv < 2) ? "R3" : ((st > 0) ? "R8" : "R2");
    @(negedge clk);
    en = 1'b0;
    div_cfg = dv[15:0];
    edge_dly = {ld[15:0], sd[15:0]};
    hold = (st > 0);
    @(negedge clk);
    chk(scl_o && !launch_stb && !sample_stb, "R1", {scl_o, launch_stb, sample_stb}, 3'b100);
    en = 1'b1;
    t = 0; scnt = 0; rise_t = -1; fall2_t = -1; l1 = -1; s1 = -1; l2 = -1;
    nl = 0; ns = 0; prev = 1'b1;
    while (t < fall2_exp + le + 1) begin
      @(negedge clk);
      t++;
      if (t == 1) chk(scl_o == 1'b0, "R9", scl_o, 0);
      if (scl_o && !prev && rise_t < 0) rise_t = t;
      if (!scl_o && prev && t > 1 && fall2_t < 0) fall2_t = t;
      if (launch_stb) begin
        if (fall2_t < 0) begin nl++; if (l1 < 0) l1 = t; end
        else if (l2 < 0) l2 = t;
      end
      if (sample_stb && (fall2_t < 0 || t == fall2_t)) begin
        ns++;
        if (s1 < 0) s1 = t;
      end
      prev = scl_o;
      if (scl_o && hold) begin
        if (scnt == st) hold = 1'b0;
        else scnt++;
      end
    end
    chk(rise_t == 1 + h, (dv < 2) ? "R3" : "R2", rise_t, 1 + h);
    chk(fall2_t == fall2_exp, ptag, fall2_t, fall2_exp);
    chk(l1 == 1 + le, dtag(ld, h, "R4"), l1, 1 + le);
    chk(s1 == r_exp + se, (st > 0) ? "R8" : dtag(sd, h, "R5"), s1, r_exp + se);
    chk(nl == 1, "R4", nl, 1);
    chk(ns == 1, "R5", ns, 1);
    chk(l2 == fall2_exp + le, "R4", l2, fall2_exp + le);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(scl_o && !launch_stb && !sample_stb, "R1", {scl_o, launch_stb, sample_stb}, 3'b100);
    @(negedge clk);
    rst = 1'b0;
    run_case(2, 0, 0, 0);      // R6, smallest period
    run_case(7, 3, 3, 0);      // R2 odd divider acts as 6
    run_case(20, 10, 10, 4);   // delays equal to H, stretch R8
    run_case(9, 100, 0, 2);    // R7 clamp, R6
    run_case(12, 1, 6, 0);
    for (int i = 0; i < 16; i++) begin
      run_case(2 + int'($urandom % 63), int'($urandom % 40), int'($urandom % 40),
               int'($urandom % 6));
    end
    run_case(1, 2, 3, 0);      // R3 bit 0 only
    run_case(0, 5, 5, 0);      // R3 zero divider
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule